// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block gathers level-sensitive interrupt requests from up to 64 PCI functions and folds them onto four shared interrupt lines, A to D. Each function reports its request level, its slot number and the value of its interrupt-pin register. The pin is rotated by the slot number before it lands on a shared line, so that functions in neighbouring slots spread across all four lines instead of piling onto line A.

Each shared line then passes through a route register that names one of sixteen legacy interrupt-controller inputs, or disconnects the line altogether. The block also keeps the two trigger-mode bytes that mark each of the sixteen legacy inputs as edge- or level-triggered. All registers are loaded through one write port. The legacy request vector is registered.

Top module: `pirq_steer`

## Requirements
- R1: A function whose pin register holds p (1 = INTA, 2 = INTB, 3 = INTC, 4 = INTD) and whose slot number is s drives shared line ((p - 1) + s) mod 4, lines numbered 0 = A to 3 = D.
- R2: A shared line is high while any function mapped onto it requests, and low once all of them have released.
- R3: Writing value v to register address 0, 1, 2 or 3 sets the route of shared line A, B, C or D; a value below 16 steers that line to legacy output v.
- R4: A route value of 16 or more disconnects the shared line from every legacy output; every route resets to 0x80, so nothing reaches the outputs until a route is written.
- R5: Address 4 holds the trigger byte for legacy inputs 0 to 7 and address 5 for inputs 8 to 15; bit (n mod 8) of byte (n / 8) appears on trig_level[n], and both bytes reset to zero.
- R6: A function whose pin register is zero has no effect on any output, whatever its request level.
- R7: When several shared lines route to the same legacy number, that output is the OR of those lines.
- R8: A change of request level reaches leg_irq exactly one clock edge after it is sampled, and never before.
- R9: A route write takes effect on leg_irq at the edge after the write edge; outputs fed by other routes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | NDEV | Request level per function |
| dev_slot | input | NDEV*SLOTW | Slot number per function, packed |
| dev_pin | input | NDEV*PINW | Interrupt-pin register per function, packed (0 = none, 1..4 = INTA..INTD) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address: 0..3 routes, 4..5 trigger bytes |
| reg_data | input | 8 | Register write data |
| leg_irq | output | NLEG | Registered legacy interrupt requests |
| trig_level | output | NLEG | Trigger mode per legacy input, 1 = level |

## Verification
The assertions assume that pin registers hold only 0 to 4 and that a write strobe always carries a settled address and data; values 5 to 7 in a pin field would fold onto a line but are not part of the contract. The stimulus keeps every pin value inside that range and changes inputs only on the falling edge, one stimulus set per cycle. Register changes are issued as single-cycle strobes, so the hold properties on the route and trigger registers see idle cycles between writes.

// File: rtl/pirq_steer.sv
module pirq_steer #(
  parameter int NDEV  = 64,
  parameter int NLEG  = 16,
  parameter int SLOTW = 5,
  parameter int PINW  = 3,
  parameter int AW    = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NDEV-1:0]        dev_req,
  input  logic [NDEV*SLOTW-1:0]  dev_slot,
  input  logic [NDEV*PINW-1:0]   dev_pin,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  logic [7:0]             reg_data,
  output logic [NLEG-1:0]        leg_irq,
  output logic [NLEG-1:0]        trig_level
);
  localparam int NLINE = 4;
  localparam int TRIGB = (NLEG + 7) / 8;
  localparam logic [7:0] ROUTE_OFF = 8'h80;

  logic [1:0]                lane [NDEV];
  logic [NDEV-1:0]           live;
  logic [NLINE-1:0]          shared;
  logic [NLINE-1:0][7:0]     route_q;
  logic [TRIGB-1:0][7:0]     trig_q;
  logic [NLEG-1:0]           leg_d;

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    assign lane[d] = dev_pin[d*PINW +: 2] - 2'd1 + dev_slot[d*SLOTW +: 2];
    assign live[d] = dev_req[d] && (dev_pin[d*PINW +: PINW] != '0);
  end

  always_comb begin
    shared = '0;
    for (int d = 0; d < NDEV; d++)
      if (live[d]) shared[lane[d]] = 1'b1;
  end

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    logic [NLINE-1:0] hit;
    for (genvar k = 0; k < NLINE; k++) begin : g_line
      assign hit[k] = shared[k] && (route_q[k] == 8'(i));
    end
    assign leg_d[i]      = |hit;
    assign trig_level[i] = trig_q[i/8][i%8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) leg_irq <= '0;
    else        leg_irq <= leg_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NLINE; k++) route_q[k] <= ROUTE_OFF;
      trig_q <= '0;
    end else if (reg_wr) begin
      for (int k = 0; k < NLINE; k++)
        if (reg_addr == AW'(k)) route_q[k] <= reg_data;
      for (int t = 0; t < TRIGB; t++)
        if (reg_addr == AW'(NLINE + t)) trig_q[t] <= reg_data;
    end
  end

  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int k = 0; k < NLINE; k++)
      if (route_q[k] < 8'(NLEG)) all_off = 1'b0;
  end

  AST_ROUTES_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |=> (leg_irq == '0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (shared == '0) |=> (leg_irq == '0)); // R8
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(route_q)); // R3
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(trig_q)); // R5
  AST_FANIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(leg_irq) <= NLINE); // R7
endmodule

// File: tb/tb_pirq_steer.sv
`timescale 1ns/1ps
module tb_pirq_steer;
  localparam int NDEV = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NDEV-1:0]   dev_req = '0;
  logic [NDEV*5-1:0] dev_slot = '0;
  logic [NDEV*3-1:0] dev_pin = '0;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [7:0]        reg_data = '0;
  logic [15:0]       leg_irq, trig_level;

  pirq_steer dut (.clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_slot(dev_slot),
    .dev_pin(dev_pin), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
    .leg_irq(leg_irq), .trig_level(trig_level));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NDEV-1:0] s_req = '0;
  logic [4:0]  s_slot [NDEV];
  logic [2:0]  s_pin  [NDEV];
  logic [7:0]  m_route [4];
  logic [15:0] m_trig = '0;
  logic [15:0] prev_exp = '0;
  logic [15:0] qleg[$], qtrig[$];
  string       qtag[$];

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_leg();
    logic [3:0] line = '0;
    logic [15:0] res = '0;
    for (int d = 0; d < NDEV; d++)
      if (s_req[d] && s_pin[d] != 0) line[(int'(s_pin[d]) - 1 + int'(s_slot[d])) % 4] = 1'b1;
    for (int k = 0; k < 4; k++)
      if (line[k] && m_route[k] < 16) res[m_route[k][3:0]] = 1'b1;
    return res;
  endfunction

  task automatic step(bit wr, logic [2:0] a, logic [7:0] dat, string tag);
    logic [15:0] exp;
    @(negedge clk);
    for (int d = 0; d < NDEV; d++) begin
      dev_slot[d*5 +: 5] = s_slot[d];
      dev_pin[d*3 +: 3]  = s_pin[d];
    end
    dev_req = s_req;
    reg_wr = wr; reg_addr = a; reg_data = dat;
    exp = model_leg();
    if (wr) begin
      if (a < 4) m_route[a[1:0]] = dat;
      else if (a == 4) m_trig[7:0] = dat;
      else if (a == 5) m_trig[15:8] = dat;
    end
    qleg.push_back(exp); qtrig.push_back(m_trig); qtag.push_back(tag);
    #1 check(leg_irq, prev_exp, {tag, " R8 pre-edge"});
    prev_exp = exp;
  endtask

  always @(posedge clk) begin
    #2;
    if (qleg.size() > 0) begin
      string t;
      logic [15:0] el, et;
      el = qleg.pop_front(); et = qtrig.pop_front(); t = qtag.pop_front();
      check(leg_irq, el, t);
      check(trig_level, et, {t, " R5 trig"});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8 actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    for (int d = 0; d < NDEV; d++) begin s_slot[d] = 5'(d % 32); s_pin[d] = 3'd0; end
    for (int k = 0; k < 4; k++) m_route[k] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(leg_irq, 16'h0, "R4 reset leg");
    check(trig_level, 16'h0, "R5 reset trig");

    step(0, 0, 0, "R4 idle");
    s_pin[0] = 3'd1; s_req[0] = 1'b1;
    step(0, 0, 0, "R4 reset routes block");
    step(1, 0, 8'd11, "R3 route A");
    step(1, 1, 8'd9,  "R3 route B");
    step(1, 2, 8'd10, "R3 route C");
    step(1, 3, 8'd5,  "R3 route D");
    s_pin[5] = 3'd1; s_req[5] = 1'b1;
    step(0, 0, 0, "R1 slot1 INTA to B");
    s_req[0] = 0; s_req[5] = 0;
    s_pin[10] = 3'd2; s_slot[10] = 5'd3; s_req[10] = 1'b1;
    step(0, 0, 0, "R1 slot3 INTB to A");
    s_req[10] = 0; s_pin[20] = 3'd4; s_slot[20] = 5'd2; s_req[20] = 1'b1;
    step(0, 0, 0, "R1 slot2 INTD to B");
    s_req[20] = 0; s_pin[33] = 3'd3; s_req[33] = 1'b1;
    step(0, 0, 0, "R1 slot1 INTC to D");
    s_req[33] = 0; s_req[0] = 1; s_req[10] = 1;
    step(0, 0, 0, "R2 two on A");
    s_req[0] = 0;
    step(0, 0, 0, "R2 one left on A");
    s_req[10] = 0;
    step(0, 0, 0, "R2 all released");
    s_req[40] = 1'b1;
    step(0, 0, 0, "R6 pin zero ignored");
    step(1, 2, 8'd11, "R7 route C to 11");
    s_pin[44] = 3'd3; s_req[44] = 1'b1;
    step(0, 0, 0, "R7 C alone on 11");
    s_req[0] = 1'b1;
    step(0, 0, 0, "R7 A and C on 11");
    s_req[0] = 0; s_req[44] = 0;
    step(0, 0, 0, "R7 both released");
    step(1, 1, 8'h10, "R4 route B 16");
    s_req[5] = 1'b1;
    step(0, 0, 0, "R4 B disconnected");
    step(1, 1, 8'hFF, "R4 route B FF");
    step(0, 0, 0, "R4 B still disconnected");
    s_req[5] = 0;
    step(1, 4, 8'h20, "R5 trig low");
    step(1, 5, 8'h0E, "R5 trig high");
    s_req[0] = 1; s_req[33] = 1;
    step(0, 0, 0, "R9 before reroute");
    step(1, 0, 8'd3, "R9 write edge keeps old");
    step(0, 0, 0, "R9 rerouted to 3");
    s_req[0] = 0; s_req[33] = 0;
    step(0, 0, 0, "R8 release");
    step(0, 0, 0, "R8 drain");
    while (qleg.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule